// File: doc/BRIEF.md
# Auto-Reload Overflow Timer with Debug Suspend

This block is a 32-bit up-counter that runs from a programmable start value to the all-ones value. When it wraps past all-ones, it reloads the start value and issues a one-clock overflow pulse. The pulse sets a sticky status flag. Software clears that flag with a write-one-to-clear strobe, and an enable bit gates it onto the interrupt output. An optional prescaler can slow the counter by a power of two between 2 and 256. New prescaler settings are adopted only at the end of a prescaler period, so no period is ever cut short.

A debug-suspend pin may arrive from any clock domain. Two flops synchronize it. Once synchronized, it freezes both the prescaler and the counter, unless the free-run bit is set. When suspend is released, counting continues from the held values.

A small state machine controls the block. Its states are IDLE (stopped, prescaler cleared), RUN (counting) and HALT (frozen by suspend). Its transitions are:
- START (IDLE to RUN): loads the counter with the start value.
- FREEZE (RUN to HALT).
- RESUME (HALT to RUN).
- STOP (RUN or HALT to IDLE): taken whenever `start` is low.

Top module: `reload_timer`

## Requirements
- R1: With the block in IDLE, a clock edge that samples `start` high loads `count` with `load_val` and moves the block to RUN (START).
- R2: With `psc_en` low, `count` rises by exactly one on every clock edge while running.
- R3: With `psc_en` high, `count` rises once every 2^(`psc_ratio`+1) clocks. The 3-bit `psc_ratio` values 0, 2 and 7 give 2, 8 and 256 clocks. After START, the first increment lands on the edge that is that many clocks after the load edge.
- R4: On the tick where `count` is 0xFFFFFFFF, `count` reloads `load_val` and `ovf_pulse` is high for that one cycle. With `load_val` = 0xFFFFFFFE and no prescaler, an overflow occurs every 2 clocks.
- R5: An overflow sets a sticky status bit. `irq_clr` high clears it on the next edge, but a simultaneous overflow wins. `irq` equals status AND `irq_en`, with no added delay.
- R6: `suspend_async` passes through two flops. A change is first seen by the counter on the third rising edge after the change, so the two edges that follow the change still count.
- R7: With `free_run` low and suspend active, `count` and the prescaler hold (FREEZE, HALT). After release, counting resumes from the held value (RESUME).
- R8: With `free_run` high, suspend is ignored and `count` keeps advancing.
- R9: `start` low stops counting at once: `count` holds, the prescaler clears, and the block returns to IDLE (STOP).
- R10: A change of `psc_ratio` or `psc_en` made mid-period takes effect only after the current prescaler period ends.
- R11: After reset, `count` is 0 and both `ovf_pulse` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run enable; rising in IDLE loads the counter |
| load_val | input | 32 | Start / reload value |
| psc_en | input | 1 | Prescaler enable |
| psc_ratio | input | 3 | Prescaler exponent; divide by 2^(value+1) |
| free_run | input | 1 | 1 = ignore suspend |
| suspend_async | input | 1 | Asynchronous debug-suspend request |
| irq_en | input | 1 | Interrupt mask |
| irq_clr | input | 1 | Write-one-to-clear for the status bit |
| ovf_pulse | output | 1 | One-cycle overflow pulse |
| irq | output | 1 | Masked sticky overflow interrupt |
| count | output | 32 | Counter readback |

## Verification
Any error in the prescaler counter or in its latched settings changes the spacing of `count` increments. This shows up within one prescaler period, at most 256 clocks. A wrong state-machine state shows up on the next clock in one of three ways: `count` moves when it should hold, it stalls when it should move, or START fails to load `load_val`. An off-by-one in synchronizer depth moves the first frozen edge by one clock, and the bench samples that exact edge. A reload or status fault shows on `count` and `irq` in the cycle right after the wrap.

// File: rtl/timer_pkg.sv
package timer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } tmr_state_t;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int RATIO_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               adv,
    input  logic               en_in,
    input  logic [RATIO_W-1:0] ratio_in,
    output logic               tick
);
    localparam int CNT_W = 2 ** RATIO_W;

    logic               cfg_en;
    logic [RATIO_W-1:0] cfg_ratio;
    logic [CNT_W-1:0]   cnt;
    logic [RATIO_W:0]   shamt;
    logic [CNT_W:0]     last_w;

    always_comb begin
        shamt  = {1'b0, cfg_ratio} + {{RATIO_W{1'b0}}, 1'b1};
        last_w = ({{CNT_W{1'b0}}, 1'b1} << shamt) - {{CNT_W{1'b0}}, 1'b1};
        tick   = adv && (!cfg_en || ({1'b0, cnt} == last_w));
    end

    // settings are latched only at a period boundary (R10)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            cfg_en    <= 1'b0;
            cfg_ratio <= '0;
        end else if (clear || tick) begin
            cnt       <= '0;
            cfg_en    <= en_in;
            cfg_ratio <= ratio_in;
        end else if (adv) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_PSC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0));                               // R9

    AST_PSC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clear) |=> $stable(cnt));                   // R7
endmodule

// File: rtl/reload_timer.sv
module reload_timer
    import timer_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int RATIO_W = 3,
    parameter int SYNC_N  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [CNT_W-1:0]   load_val,
    input  logic               psc_en,
    input  logic [RATIO_W-1:0] psc_ratio,
    input  logic               free_run,
    input  logic               suspend_async,
    input  logic               irq_en,
    input  logic               irq_clr,
    output logic               ovf_pulse,
    output logic               irq,
    output logic [CNT_W-1:0]   count
);
    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

    tmr_state_t state, state_nx;
    logic susp_s, freeze, running, psc_clear, tick, status;

    tmr_sync #(.STAGES(SYNC_N)) i_sync (
        .clk(clk), .rst_n(rst_n), .din(suspend_async), .dout(susp_s)
    );

    assign freeze    = susp_s && !free_run;
    assign running   = start && (state != ST_IDLE) && !freeze;
    assign psc_clear = !start || (state == ST_IDLE);

    tmr_prescale #(.RATIO_W(RATIO_W)) i_psc (
        .clk(clk), .rst_n(rst_n), .clear(psc_clear), .adv(running),
        .en_in(psc_en), .ratio_in(psc_ratio), .tick(tick)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions: START, FREEZE, RESUME, STOP
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_RUN;
            ST_RUN:  if (!start) state_nx = ST_IDLE;
                     else if (freeze) state_nx = ST_HALT;
            ST_HALT: if (!start) state_nx = ST_IDLE;
                     else if (!freeze) state_nx = ST_RUN;
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs: counter, overflow pulse, sticky status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count     <= '0;
            ovf_pulse <= 1'b0;
            status    <= 1'b0;
        end else begin
            ovf_pulse <= 1'b0;
            if (state == ST_IDLE && start) begin
                count <= load_val;
            end else if (tick) begin
                if (count == ALL_ONES) begin
                    count     <= load_val;
                    ovf_pulse <= 1'b1;
                end else begin
                    count <= count + 1'b1;
                end
            end
            if (tick && state != ST_IDLE && count == ALL_ONES) status <= 1'b1;
            else if (irq_clr) status <= 1'b0;
        end
    end

    assign irq = status && irq_en;

    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> (count == $past(load_val)));            // R4

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_pulse && irq_en) |-> irq);                       // R5

    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(count));                           // R9

    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && state != ST_IDLE) |=> $stable(count));     // R7

    AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> (count == $past(load_val))); // R1
endmodule

// File: tb/test_reload_timer.sv
module test_reload_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] load_val = '0;
    logic        psc_en = 1'b0;
    logic [2:0]  psc_ratio = '0;
    logic        free_run = 1'b0;
    logic        suspend_async = 1'b0;
    logic        irq_en = 1'b0;
    logic        irq_clr = 1'b0;
    logic        ovf_pulse, irq;
    logic [31:0] count;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    reload_timer i_reload_timer (
        .clk(clk), .rst_n(rst_n), .start(start), .load_val(load_val),
        .psc_en(psc_en), .psc_ratio(psc_ratio), .free_run(free_run),
        .suspend_async(suspend_async), .irq_en(irq_en), .irq_clr(irq_clr),
        .ovf_pulse(ovf_pulse), .irq(irq), .count(count)
    );

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic restart(logic [31:0] lv, logic pe, logic [2:0] pr);
        start = 1'b0;
        step(1);
        load_val  = lv;
        psc_en    = pe;
        psc_ratio = pr;
        start     = 1'b1;
        step(1);
    endtask

    // edges from the load edge until count changes
    task automatic gap(output int n);
        logic [31:0] v;
        v = count;
        n = 0;
        while (count == v && n < 600) begin
            step(1);
            n++;
        end
    endtask

    task automatic t_reset;
        check("R11 count after reset", count, 32'h0);
        check("R11 ovf after reset", {31'b0, ovf_pulse}, 32'h0);
        check("R11 irq after reset", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_start_plain;
        restart(32'h100, 1'b0, 3'd0);
        check("R1 load on start", count, 32'h100);
        step(5);
        check("R2 one per clock", count, 32'h105);
    endtask

    task automatic t_prescale;
        int n;
        restart(32'h10, 1'b1, 3'd0);
        gap(n);
        check("R3 ratio 0 divides by 2", n, 2);
        restart(32'h10, 1'b1, 3'd2);
        gap(n);
        check("R3 ratio 2 divides by 8", n, 8);
        gap(n);
        check("R3 ratio 2 second period", n, 8);
        restart(32'h10, 1'b1, 3'd7);
        gap(n);
        check("R3 ratio 7 divides by 256", n, 256);
    endtask

    task automatic t_ratio_change;
        int n;
        restart(32'h20, 1'b1, 3'd2);
        step(3);
        psc_ratio = 3'd0;
        gap(n);
        check("R10 old ratio finishes period", n + 3, 8);
        gap(n);
        check("R10 new ratio after boundary", n, 2);
        psc_en = 1'b0;
        gap(n);
        check("R10 enable change at boundary", n, 2);
        gap(n);
        check("R10 prescaler off afterwards", n, 1);
    endtask

    task automatic t_overflow;
        int pulses = 0;
        int bad = 0;
        restart(32'hFFFF_FFFE, 1'b0, 3'd0);
        for (int i = 0; i < 20; i++) begin
            step(1);
            if (ovf_pulse) begin
                pulses++;
                if (count != 32'hFFFF_FFFE) bad++;
            end
        end
        check("R4 overflow every 2 clocks", pulses, 10);
        check("R4 reload value after wrap", bad, 0);
    endtask

    task automatic t_irq;
        irq_en = 1'b0;
        restart(32'hFFFF_FFFE, 1'b0, 3'd0);
        step(3);
        check("R5 irq masked", {31'b0, irq}, 32'h0);
        irq_en = 1'b1;
        #1;
        check("R5 irq unmasked shows status", {31'b0, irq}, 32'h1);
        start = 1'b0;
        step(1);
        irq_clr = 1'b1;
        step(1);
        irq_clr = 1'b0;
        check("R5 irq_clr clears status", {31'b0, irq}, 32'h0);
        irq_en = 1'b0;
    endtask

    task automatic t_suspend;
        logic [31:0] v0, v;
        free_run = 1'b0;
        restart(32'h0, 1'b0, 3'd0);
        v0 = count;
        suspend_async = 1'b1;
        step(2);
        check("R6 two edges still count", count, v0 + 2);
        v = count;
        step(10);
        check("R7 count held while suspended", count, v);
        suspend_async = 1'b0;
        step(2);
        check("R6 release delayed by sync", count, v);
        step(1);
        check("R7 resume from held value", count, v + 1);
    endtask

    task automatic t_free_run;
        logic [31:0] v;
        free_run = 1'b1;
        restart(32'h0, 1'b0, 3'd0);
        suspend_async = 1'b1;
        v = count;
        step(10);
        check("R8 free run ignores suspend", count, v + 10);
        suspend_async = 1'b0;
        free_run = 1'b0;
        step(3);
    endtask

    task automatic t_stop;
        logic [31:0] v;
        restart(32'h50, 1'b0, 3'd0);
        step(4);
        v = count;
        start = 1'b0;
        step(6);
        check("R9 count held after stop", count, v);
        psc_en = 1'b1;
        psc_ratio = 3'd1;
        start = 1'b1;
        step(1);
        check("R9 restart loads again", count, 32'h50);
        start = 1'b0;
        step(1);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        step(3);
        t_reset();
        rst_n = 1'b1;
        step(1);
        t_start_plain();
        t_prescale();
        t_ratio_change();
        t_overflow();
        t_irq();
        t_suspend();
        t_free_run();
        t_stop();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule